// File: doc/BRIEF.md
# Epoch-Based Switch Fabric Allocator

This block chooses, once per epoch, which source cards of a 15-port switched backplane may send to which destination cards. The source cards present a full request matrix, the destination cards present a flow-control inhibit vector, and each source carries a flag that marks it as a forwarding engine. The allocator builds a one-to-one pairing of sources and destinations. It publishes that pairing on two grant views: one indexed by source and one indexed by destination.

An epoch lasts eight allocation clock cycles, and `epoch_start_o` marks the first of them. The inputs are captured on the edge that closes that first cycle. The pairing is built over the next six cycles, and each cycle checks five source rows against every destination in a combinational chain. Forwarding-engine sources are served in a first pass and line-card sources in a second pass. The result goes to the grant outputs at the epoch boundary and holds for the whole of the following epoch.

Fixed scan order would favour low-numbered ports. To prevent this, the starting point of both the source scan and the destination scan is rotated each epoch by offsets taken from a 16-bit LFSR.

Top module: `epoch_alloc`

## Requirements
- R1: An epoch is 8 clock cycles. `epoch_start_o` is 1 in the first cycle of every epoch and 0 in the other seven. The first epoch begins in the first cycle after `rst_ni` is released.
- R2: `req_i` (bit s*15+d requests source s to destination d), `inhibit_i` and `fe_src_i` are sampled only at the rising edge that ends an `epoch_start_o` cycle. Changes at any other time have no effect on the grants.
- R3: The pairing computed from the inputs sampled in epoch k appears on all grant outputs for every cycle of epoch k+1 and does not change within that epoch. During reset and throughout epoch 0, all grant outputs are 0.
- R4: The grants are one-to-one: no source holds two destinations and no destination holds two sources. If source s is granted destination d, then destination d is granted source s. An index field whose valid bit is 0 reads 0. Index fields are 4 bits, and port p occupies bits [4p+3:4p].
- R5: A grant is issued only for a pair whose request bit was set.
- R6: A destination whose inhibit bit was set is never granted.
- R7: All sources with `fe_src_i` set are allocated before any source without it. Within each of the two passes, sources are visited in the rotated order of R8.
- R8: Let L be the LFSR value for the epoch, and let F = L[3:0]^L[11:8] and G = L[7:4]^L[15:12]. The source scan starts at F mod 15 and the destination scan starts at G mod 15, and both increase with wraparound. The LFSR starts at 0xACE1 for epoch 0, shifts left once per epoch, and feeds bit 0 with L[15]^L[13]^L[12]^L[10].
- R9: Each visited source takes the first destination in scan order that it requested, that is not inhibited and that is still free. A full request matrix with no inhibit therefore yields 15 grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Allocation clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 225 | Request matrix, bit s*15+d |
| inhibit_i | input | 15 | Per-destination inhibit |
| fe_src_i | input | 15 | Per-source forwarding-engine flag |
| epoch_start_o | output | 1 | First cycle of an epoch |
| src_gnt_vld_o | output | 15 | Source s holds a grant |
| src_gnt_dst_o | output | 60 | Destination index per source, 4 bits each |
| dst_gnt_vld_o | output | 15 | Destination d holds a grant |
| dst_gnt_src_o | output | 60 | Source index per destination, 4 bits each |

## Verification
The hardest case to reach from the ports is a contested destination. There, the outcome depends on the LFSR-driven scan offsets and on the two-pass priority order at the same time. A wrong rotation or pass order still produces a legal pairing, so only an exact comparison can expose it. The bench therefore runs its own model of the LFSR across every consecutive epoch and predicts the exact pairing for each stimulus. The stimuli include a whole column contested by all sources with a single forwarding-engine source, full matrices with partial inhibit, and random sparse matrices. In the middle of each epoch, the bench scrambles the inputs to prove that only the epoch-start sample counts.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  // wrap a sum known to be below 2*n into [0, n)
  function automatic int unsigned wrap_idx(int unsigned v, int unsigned n);
    return (v >= n) ? v - n : v;
  endfunction
endpackage

// File: rtl/alloc_epoch_timer.sv
module alloc_epoch_timer #(
  parameter int EPOCH_CYCLES = 8,
  localparam int CNTW = $clog2(EPOCH_CYCLES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [CNTW-1:0] cnt_o,
  output logic            start_o,
  output logic            last_o
);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign start_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CNTW'(EPOCH_CYCLES - 1));
endmodule

// File: rtl/alloc_lfsr.sv
module alloc_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hB400,
  parameter logic [W-1:0]    SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= SEED;
    else if (step_i) st_q <= {st_q[W-2:0], ^(st_q & TAPS)};
  end

  assign state_o = st_q;
endmodule

// File: rtl/alloc_pick.sv
module alloc_pick
  import alloc_pkg::*;
#(
  parameter int N_PORTS = 15,
  localparam int IDXW = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0] row_i,
  input  logic [N_PORTS-1:0] blocked_i,
  input  logic [IDXW-1:0]    off_i,
  output logic               hit_o,
  output logic [IDXW-1:0]    idx_o
);
  always_comb begin
    int unsigned d;
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      d = wrap_idx(int'(off_i) + k, N_PORTS);
      if (!hit_o && row_i[d] && !blocked_i[d]) begin
        hit_o = 1'b1;
        idx_o = IDXW'(d);
      end
    end
  end
endmodule

// File: rtl/epoch_alloc.sv
module epoch_alloc
  import alloc_pkg::*;
#(
  parameter int                 N_PORTS      = 15,
  parameter int                 EPOCH_CYCLES = 8,
  parameter int                 SRC_PER_CYC  = 5,
  parameter int                 LFSR_W       = 16,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS    = 16'hB400,
  parameter logic [LFSR_W-1:0]  LFSR_SEED    = 16'hACE1,
  localparam int IDXW   = $clog2(N_PORTS),
  localparam int CNTW   = $clog2(EPOCH_CYCLES),
  localparam int GROUPS = (N_PORTS + SRC_PER_CYC - 1) / SRC_PER_CYC
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_PORTS*N_PORTS-1:0] req_i,
  input  logic [N_PORTS-1:0]        inhibit_i,
  input  logic [N_PORTS-1:0]        fe_src_i,
  output logic                      epoch_start_o,
  output logic [N_PORTS-1:0]        src_gnt_vld_o,
  output logic [N_PORTS*IDXW-1:0]   src_gnt_dst_o,
  output logic [N_PORTS-1:0]        dst_gnt_vld_o,
  output logic [N_PORTS*IDXW-1:0]   dst_gnt_src_o
);
  // epoch timing
  logic [CNTW-1:0] cnt;
  logic            ep_start, ep_last;

  alloc_epoch_timer #(.EPOCH_CYCLES(EPOCH_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_o   (cnt),
    .start_o (ep_start),
    .last_o  (ep_last)
  );

  // per-epoch shuffle source
  logic [LFSR_W-1:0] lfsr;

  alloc_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (ep_last),
    .state_o (lfsr)
  );

  logic [2*IDXW-1:0] fold;
  logic [IDXW-1:0]   src_off_d, dst_off_d;

  always_comb begin
    fold = '0;
    for (int i = 0; i < LFSR_W; i++) fold[i % (2*IDXW)] ^= lfsr[i];
    src_off_d = IDXW'(wrap_idx(int'(fold[IDXW-1:0]), N_PORTS));
    dst_off_d = IDXW'(wrap_idx(int'(fold[2*IDXW-1:IDXW]), N_PORTS));
  end

  // step decode: pass 0 serves forwarding engines, pass 1 line cards
  logic step_act, pass_lc;
  int   grp;

  always_comb begin
    int s1;
    s1       = int'(cnt) - 1;
    step_act = (s1 >= 0) && (s1 < 2*GROUPS);
    pass_lc  = (s1 >= GROUPS);
    grp      = pass_lc ? s1 - GROUPS : s1;
  end

  // epoch snapshot
  logic [N_PORTS*N_PORTS-1:0] req_q;
  logic [N_PORTS-1:0]         inh_q, fe_q;
  logic [IDXW-1:0]            src_off_q, dst_off_q;

  // working configuration and published configuration
  logic [N_PORTS-1:0] ws_vld, wd_vld, os_vld, od_vld;
  logic [IDXW-1:0]    ws_dst [N_PORTS];
  logic [IDXW-1:0]    wd_src [N_PORTS];
  logic [IDXW-1:0]    os_dst [N_PORTS];
  logic [IDXW-1:0]    od_src [N_PORTS];

  // parallel slot chain
  logic [N_PORTS-1:0]     busy     [SRC_PER_CYC+1];
  logic [SRC_PER_CYC-1:0] take;
  logic [IDXW-1:0]        slot_src [SRC_PER_CYC];
  logic [IDXW-1:0]        slot_dst [SRC_PER_CYC];

  assign busy[0] = wd_vld;

  for (genvar j = 0; j < SRC_PER_CYC; j++) begin : g_slot
    int unsigned        pos;
    logic               slot_on, elig, hit;
    logic [N_PORTS-1:0] row;

    always_comb begin
      pos         = int'(grp) * SRC_PER_CYC + j;
      slot_on     = step_act && (pos < N_PORTS);
      slot_src[j] = slot_on ? IDXW'(wrap_idx(int'(src_off_q) + pos, N_PORTS)) : '0;
      row         = req_q[int'(slot_src[j])*N_PORTS +: N_PORTS];
      elig        = slot_on && (fe_q[slot_src[j]] != pass_lc) && !ws_vld[slot_src[j]];
    end

    alloc_pick #(.N_PORTS(N_PORTS)) u_pick (
      .row_i     (row),
      .blocked_i (inh_q | busy[j]),
      .off_i     (dst_off_q),
      .hit_o     (hit),
      .idx_o     (slot_dst[j])
    );

    assign take[j]   = elig & hit;
    assign busy[j+1] = busy[j] | (take[j] ? (N_PORTS'(1) << slot_dst[j]) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= '0;
      inh_q     <= '0;
      fe_q      <= '0;
      src_off_q <= '0;
      dst_off_q <= '0;
      ws_vld    <= '0;
      wd_vld    <= '0;
      for (int p = 0; p < N_PORTS; p++) begin
        ws_dst[p] <= '0;
        wd_src[p] <= '0;
      end
    end else if (ep_start) begin
      req_q     <= req_i;
      inh_q     <= inhibit_i;
      fe_q      <= fe_src_i;
      src_off_q <= src_off_d;
      dst_off_q <= dst_off_d;
      ws_vld    <= '0;
      wd_vld    <= '0;
      for (int p = 0; p < N_PORTS; p++) begin
        ws_dst[p] <= '0;
        wd_src[p] <= '0;
      end
    end else if (step_act) begin
      for (int j = 0; j < SRC_PER_CYC; j++) begin
        if (take[j]) begin
          ws_vld[slot_src[j]] <= 1'b1;
          ws_dst[slot_src[j]] <= slot_dst[j];
          wd_vld[slot_dst[j]] <= 1'b1;
          wd_src[slot_dst[j]] <= slot_src[j];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      os_vld <= '0;
      od_vld <= '0;
      for (int p = 0; p < N_PORTS; p++) begin
        os_dst[p] <= '0;
        od_src[p] <= '0;
      end
    end else if (ep_last) begin
      os_vld <= ws_vld;
      od_vld <= wd_vld;
      for (int p = 0; p < N_PORTS; p++) begin
        os_dst[p] <= ws_dst[p];
        od_src[p] <= wd_src[p];
      end
    end
  end

  assign epoch_start_o = ep_start;
  assign src_gnt_vld_o = os_vld;
  assign dst_gnt_vld_o = od_vld;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_out
    assign src_gnt_dst_o[p*IDXW +: IDXW] = os_dst[p];
    assign dst_gnt_src_o[p*IDXW +: IDXW] = od_src[p];
  end
endmodule

// File: rtl/epoch_alloc_chk.sv
module epoch_alloc_chk #(
  parameter int N_PORTS = 15,
  localparam int IDXW = $clog2(N_PORTS)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_PORTS*N_PORTS-1:0] req_i,
  input logic [N_PORTS-1:0]         inhibit_i,
  input logic                       epoch_start_o,
  input logic [N_PORTS-1:0]         src_gnt_vld_o,
  input logic [N_PORTS*IDXW-1:0]    src_gnt_dst_o,
  input logic [N_PORTS-1:0]         dst_gnt_vld_o,
  input logic [N_PORTS*IDXW-1:0]    dst_gnt_src_o
);
  // snapshot of the inputs that the currently shown grants were built from
  logic [N_PORTS*N_PORTS-1:0] cap_req, pub_req;
  logic [N_PORTS-1:0]         cap_inh, pub_inh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_req <= '0;
      pub_req <= '0;
      cap_inh <= '0;
      pub_inh <= '0;
    end else if (epoch_start_o) begin
      pub_req <= cap_req;
      pub_inh <= cap_inh;
      cap_req <= req_i;
      cap_inh <= inhibit_i;
    end
  end

  // R1
  start_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_start_o |=> !epoch_start_o);

  // R3
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epoch_start_o |-> ($stable(src_gnt_vld_o) && $stable(src_gnt_dst_o) &&
                        $stable(dst_gnt_vld_o) && $stable(dst_gnt_src_o)));

  for (genvar s = 0; s < N_PORTS; s++) begin : g_chk
    logic [IDXW-1:0] sd;
    assign sd = src_gnt_dst_o[s*IDXW +: IDXW];

    // R4
    pair_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_gnt_vld_o[s] |-> (dst_gnt_vld_o[sd] &&
                            dst_gnt_src_o[int'(sd)*IDXW +: IDXW] == IDXW'(s)));

    // R5
    grant_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!epoch_start_o && src_gnt_vld_o[s]) |-> pub_req[s*N_PORTS + int'(sd)]);

    // R6
    inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!epoch_start_o && dst_gnt_vld_o[s]) |-> !pub_inh[s]);
  end
endmodule

bind epoch_alloc epoch_alloc_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .inhibit_i     (inhibit_i),
  .epoch_start_o (epoch_start_o),
  .src_gnt_vld_o (src_gnt_vld_o),
  .src_gnt_dst_o (src_gnt_dst_o),
  .dst_gnt_vld_o (dst_gnt_vld_o),
  .dst_gnt_src_o (dst_gnt_src_o)
);

// File: tb/epoch_alloc_tb.sv
module epoch_alloc_tb;
  localparam int N  = 15;
  localparam int IW = 4;
  localparam int NE = 30;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N*N-1:0]   req_i = '0;
  logic [N-1:0]     inhibit_i = '0;
  logic [N-1:0]     fe_src_i = '0;
  logic             epoch_start_o;
  logic [N-1:0]     src_gnt_vld_o, dst_gnt_vld_o;
  logic [N*IW-1:0]  src_gnt_dst_o, dst_gnt_src_o;

  always #4 clk_i = ~clk_i;

  epoch_alloc u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .inhibit_i     (inhibit_i),
    .fe_src_i      (fe_src_i),
    .epoch_start_o (epoch_start_o),
    .src_gnt_vld_o (src_gnt_vld_o),
    .src_gnt_dst_o (src_gnt_dst_o),
    .dst_gnt_vld_o (dst_gnt_vld_o),
    .dst_gnt_src_o (dst_gnt_src_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  int cur_sv[N], cur_sd[N], cur_dv[N], cur_ds[N];
  int prv_sv[N], prv_sd[N], prv_dv[N], prv_ds[N];
  string cur_tag, prv_tag;

  logic [N*N-1:0] s_req;
  logic [N-1:0]   s_inh, s_fe;
  logic [15:0]    lfsr_m = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // R8 + R7 + R9 reference allocation
  task automatic predict(input logic [15:0] l);
    int so, dof;
    so  = int'(l[3:0] ^ l[11:8]) % N;
    dof = int'(l[7:4] ^ l[15:12]) % N;
    for (int p = 0; p < N; p++) begin
      cur_sv[p] = 0; cur_sd[p] = 0; cur_dv[p] = 0; cur_ds[p] = 0;
    end
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < N; p++) begin
        int s;
        s = (so + p) % N;
        if ((pass == 0) != s_fe[s]) continue;
        for (int k = 0; k < N; k++) begin
          int d;
          d = (dof + k) % N;
          if (s_req[s*N+d] && !s_inh[d] && cur_dv[d] == 0) begin
            cur_sv[s] = 1; cur_sd[s] = d; cur_dv[d] = 1; cur_ds[d] = s;
            break;
          end
        end
      end
    end
  endtask

  task automatic check_outs(input string tag);
    for (int p = 0; p < N; p++) begin
      int a, e;
      a = int'(src_gnt_vld_o[p]) * 16 + int'(src_gnt_dst_o[p*IW +: IW]);
      e = prv_sv[p] * 16 + prv_sd[p];
      chk(a == e, $sformatf("%s src%0d", tag, p), a, e);
      a = int'(dst_gnt_vld_o[p]) * 16 + int'(dst_gnt_src_o[p*IW +: IW]);
      e = prv_dv[p] * 16 + prv_ds[p];
      chk(a == e, $sformatf("%s R4 dst%0d", tag, p), a, e);
    end
  endtask

  task automatic make_stim(input int e);
    s_req = '0; s_inh = '0; s_fe = '0;
    case (e)
      0: begin s_req = '1; cur_tag = "R9"; end
      1: begin for (int p = 0; p < N; p++) s_req[p*N+p] = 1'b1; cur_tag = "R5"; end
      2: begin s_req = '1; s_inh = '1; cur_tag = "R6"; end
      3: begin
        for (int p = 0; p < N; p++) s_req[p*N] = 1'b1;
        s_fe[12] = 1'b1; cur_tag = "R7";
      end
      4: begin s_req = '1; s_inh = 15'h0F0F; s_fe = 15'h5555; cur_tag = "R6"; end
      5: begin cur_tag = "R5"; end
      default: begin
        for (int b = 0; b < N*N; b++) s_req[b] = ($urandom % 4 == 0);
        for (int p = 0; p < N; p++) begin
          s_inh[p] = ($urandom % 4 == 0);
          s_fe[p]  = ($urandom % 3 == 0);
        end
        cur_tag = "R8";
      end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int p = 0; p < N; p++) begin
      prv_sv[p] = 0; prv_sd[p] = 0; prv_dv[p] = 0; prv_ds[p] = 0;
    end
    repeat (3) @(negedge clk_i);
    check_outs("R3 reset");
    rst_ni = 1'b1;
    prv_tag = "R3 epoch0";
    for (int e = 0; e <= NE; e++) begin
      #1;
      chk(epoch_start_o == 1'b1, "R1 start high", int'(epoch_start_o), 1);
      // R2: inputs scrambled mid-epoch must not show here
      check_outs({prv_tag, " R2"});
      if (e == NE) break;
      make_stim(e);
      predict(lfsr_m);
      lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
      req_i = s_req; inhibit_i = s_inh; fe_src_i = s_fe;
      repeat (3) @(negedge clk_i);
      req_i = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      inhibit_i = N'($urandom);
      fe_src_i  = N'($urandom);
      @(negedge clk_i);
      chk(epoch_start_o == 1'b0, "R1 start low", int'(epoch_start_o), 0);
      check_outs({prv_tag, " R3 hold"});
      repeat (4) @(negedge clk_i);
      for (int p = 0; p < N; p++) begin
        prv_sv[p] = cur_sv[p]; prv_sd[p] = cur_sd[p];
        prv_dv[p] = cur_dv[p]; prv_ds[p] = cur_ds[p];
      end
      prv_tag = cur_tag;
    end
    summary();
  end
endmodule